// File: doc/BRIEF.md
# DSI Packet Framer

This block turns packet requests into the byte stream that a display serial link hands to its lane layer. A request carries a two-bit virtual channel, a six-bit data type and one 16-bit header word. The block works out from the data type whether the packet is short or long. It emits the identifier byte, two header bytes and a header ECC byte. For a long packet it then emits the payload and a two-byte payload checksum.

For a pixel stream type, the header word is taken as a line length in pixels and converted into a byte count. Sync-event packets get zeroed data bytes. Null packets get their zero-filled payload from inside the block, so the payload input is never read for them. Payload bytes arrive on a valid/ready stream. When that stream runs dry, the output pauses with it.

Top module: `dsi_pkt_builder`

## Requirements
- R1: After reset, out_valid and pay_ready are low and req_ready is high.
- R2: A request is accepted on a clock edge where req_valid and req_ready are both high. The identifier byte {vc[1:0], dtype[5:0]} (channel in bits 7:6, type in bits 5:0) comes out on the next cycle with out_first high.
- R3: Every type except 39h, 09h, 3Eh and 0Eh is short. Its bytes are: identifier, word[7:0], word[15:8], ECC. out_last is high on the ECC byte.
- R4: The ECC byte has bits 7:6 at zero. Bits 5:0 are the standard display-serial header Hamming parity over D[23:0], where D[7:0] is the identifier, D[15:8] is the first data byte and D[23:16] is the second. The bit code of each header bit is listed in the bench. For example, identifier 05h with data 11h, 00h gives ECC 36h.
- R5: Types 39h, 09h, 3Eh and 0Eh are long. Their bytes are: identifier, count low byte, count high byte, ECC, count payload bytes, checksum low byte, checksum high byte. out_last is high on the final checksum byte.
- R6: The byte count is word×3 for type 3Eh, word×2 for type 0Eh, and word for the other long types, each taken modulo 2^16.
- R7: The checksum is a 16-bit CRC with polynomial x^16+x^12+x^5+1, seeded with FFFFh and fed least significant bit first (reflected form 8408h), with no final inversion. A zero-byte payload yields FFFFh.
- R8: Exactly count payload bytes are taken from the payload stream. The checksum low byte comes out on the cycle right after the last one.
- R9: For type 09h the payload bytes are 00h and pay_ready stays low, so no byte is taken from the payload stream.
- R10: For types 01h, 11h, 21h and 31h, both data bytes are 00h whatever the header word holds.
- R11: During a payload phase with pay_valid low, out_valid is low and the packet does not advance.
- R12: req_ready is low whenever a packet is being emitted (out_valid high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Packet request present |
| req_ready | output | 1 | Framer idle, request may be taken |
| req_vc | input | 2 | Virtual channel |
| req_dtype | input | 6 | Data type |
| req_word | input | 16 | Data bytes (short), byte count or pixel count (long) |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken this cycle if valid |
| pay_data | input | 8 | Payload byte |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_first | output | 1 | Identifier byte of a packet |
| out_last | output | 1 | Final byte of a packet |

## Verification
The bench checks the header ECC against a known short command. It then runs headers on all four virtual channels, and a mis-wired parity mask shows up there as a wrong fourth byte. A long packet with a zero count has to go straight from ECC to an FFFFh checksum. A framer that off-by-ones its counter would instead pull an extra byte or skip the checksum. Two more cases target the payload path: pixel-stream counts catch a missing ×3/×2 scaling, and a null packet with a live payload stream catches a framer that pulls real data. A stalled payload stream must give the same bytes as an unstalled one, and this catches a counter that keeps advancing while the input is empty.

// File: rtl/dsi_pkt_pkg.sv
`timescale 1ns/1ps
package dsi_pkt_pkg;

  localparam int unsigned HDR_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ECC_BITS = 6;

  localparam logic [5:0] DT_NULL     = 6'h09;
  localparam logic [5:0] DT_DCS_LONG = 6'h39;
  localparam logic [5:0] DT_PIX24    = 6'h3E;
  localparam logic [5:0] DT_PIX16    = 6'h0E;
  localparam logic [5:0] DT_VS_START = 6'h01;
  localparam logic [5:0] DT_VS_END   = 6'h11;
  localparam logic [5:0] DT_HS_START = 6'h21;
  localparam logic [5:0] DT_HS_END   = 6'h31;

  localparam logic [15:0] CRC_SEED     = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_REV = 16'h8408;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DI, ST_B0, ST_B1, ST_ECC, ST_PAY, ST_CRCL, ST_CRCH
  } seq_state_t;

  // header bits covered by each parity bit
  function automatic logic [23:0] ecc_mask(input int unsigned idx);
    case (idx)
      0:       return 24'hF12CB7;
      1:       return 24'hF2555B;
      2:       return 24'h749A6D;
      3:       return 24'hB8E38E;
      4:       return 24'hDF03F0;
      default: return 24'hEFFC00;
    endcase
  endfunction

  // one payload byte into the reflected CRC, bit 0 first
  function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in,
                                             input logic [7:0]  b);
    logic [15:0] c;
    logic        fb;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = c >> 1;
      if (fb) c = c ^ CRC_POLY_REV;
    end
    return c;
  endfunction

  function automatic logic is_long_type(input logic [5:0] dt);
    return (dt == DT_DCS_LONG) || (dt == DT_NULL) ||
           (dt == DT_PIX24)    || (dt == DT_PIX16);
  endfunction

  function automatic logic is_sync_type(input logic [5:0] dt);
    return (dt == DT_VS_START) || (dt == DT_VS_END) ||
           (dt == DT_HS_START) || (dt == DT_HS_END);
  endfunction

endpackage

// File: rtl/dsi_type_decode.sv
`timescale 1ns/1ps
module dsi_type_decode
  import dsi_pkt_pkg::*;
(
  input  logic [5:0]       dtype,
  input  logic [HDR_W-1:0] word,
  output logic             is_long,
  output logic             is_null,
  output logic [HDR_W-1:0] count,
  output logic [7:0]       hb0,
  output logic [7:0]       hb1
);
  localparam int unsigned EXT_W = HDR_W + 2;

  logic [EXT_W-1:0] times3;
  logic [HDR_W-1:0] times2;
  logic             sync_t;

  assign times3  = {2'b00, word} + {1'b0, word, 1'b0};
  assign times2  = {word[HDR_W-2:0], 1'b0};
  assign is_long = is_long_type(dtype);
  assign is_null = (dtype == DT_NULL);
  assign sync_t  = is_sync_type(dtype);

  always_comb begin
    if (dtype == DT_PIX24)      count = times3[HDR_W-1:0];
    else if (dtype == DT_PIX16) count = times2;
    else                        count = word;
  end

  always_comb begin
    if (sync_t) begin
      hb0 = 8'h00;
      hb1 = 8'h00;
    end else begin
      hb0 = count[7:0];
      hb1 = count[15:8];
    end
  end
endmodule

// File: rtl/dsi_hdr_ecc.sv
`timescale 1ns/1ps
module dsi_hdr_ecc
  import dsi_pkt_pkg::*;
(
  input  logic [23:0] hdr,
  output logic [7:0]  ecc
);
  logic [ECC_BITS-1:0] par;

  for (genvar g = 0; g < ECC_BITS; g++) begin : g_par
    assign par[g] = ^(hdr & ecc_mask(g));
  end

  assign ecc = {{(8-ECC_BITS){1'b0}}, par};
endmodule

// File: rtl/dsi_crc16_acc.sv
`timescale 1ns/1ps
module dsi_crc16_acc
  import dsi_pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= CRC_SEED;
    else if (clear) crc <= CRC_SEED;
    else if (en)    crc <= crc16_byte(crc, din);
  end
endmodule

// File: rtl/dsi_pkt_builder.sv
`timescale 1ns/1ps
module dsi_pkt_builder
  import dsi_pkt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [1:0]  req_vc,
  input  logic [5:0]  req_dtype,
  input  logic [15:0] req_word,
  input  logic        pay_valid,
  output logic        pay_ready,
  input  logic [7:0]  pay_data,
  output logic        out_valid,
  output logic [7:0]  out_data,
  output logic        out_first,
  output logic        out_last
);
  seq_state_t       st_q, st_d;
  logic [7:0]       di_q, b0_q, b1_q, ecc_q;
  logic             long_q, null_q;
  logic [HDR_W-1:0] left_q;

  logic             dec_long, dec_null;
  logic [HDR_W-1:0] dec_count;
  logic [7:0]       dec_b0, dec_b1, dec_ecc, di_in;
  logic [15:0]      crc_val;

  // named events
  logic             hdr_take;
  logic             byte_fire;
  logic             last_pay;
  logic [7:0]       pay_byte;

  assign di_in    = {req_vc, req_dtype};
  assign hdr_take = (st_q == ST_IDLE) && req_valid;

  dsi_type_decode u_dec (
    .dtype   (req_dtype),
    .word    (req_word),
    .is_long (dec_long),
    .is_null (dec_null),
    .count   (dec_count),
    .hb0     (dec_b0),
    .hb1     (dec_b1)
  );

  dsi_hdr_ecc u_ecc (
    .hdr ({dec_b1, dec_b0, di_in}),
    .ecc (dec_ecc)
  );

  assign pay_byte  = null_q ? 8'h00 : pay_data;
  assign byte_fire = (st_q == ST_PAY) && (null_q || pay_valid);
  assign last_pay  = byte_fire && (left_q == HDR_W'(1));

  dsi_crc16_acc u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (hdr_take),
    .en    (byte_fire),
    .din   (pay_byte),
    .crc   (crc_val)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE: if (hdr_take) st_d = ST_DI;
      ST_DI:   st_d = ST_B0;
      ST_B0:   st_d = ST_B1;
      ST_B1:   st_d = ST_ECC;
      ST_ECC: begin
        if (!long_q)                  st_d = ST_IDLE;
        else if (left_q == '0)        st_d = ST_CRCL;
        else                          st_d = ST_PAY;
      end
      ST_PAY:  if (last_pay) st_d = ST_CRCL;
      ST_CRCL: st_d = ST_CRCH;
      ST_CRCH: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      di_q   <= '0;
      b0_q   <= '0;
      b1_q   <= '0;
      ecc_q  <= '0;
      long_q <= 1'b0;
      null_q <= 1'b0;
      left_q <= '0;
    end else begin
      st_q <= st_d;
      if (hdr_take) begin
        di_q   <= di_in;
        b0_q   <= dec_b0;
        b1_q   <= dec_b1;
        ecc_q  <= dec_ecc;
        long_q <= dec_long;
        null_q <= dec_null && dec_long;
        left_q <= dec_long ? dec_count : '0;
      end else if (byte_fire) begin
        left_q <= left_q - HDR_W'(1);
      end
    end
  end

  always_comb begin
    out_valid = 1'b1;
    out_data  = 8'h00;
    case (st_q)
      ST_DI:   out_data = di_q;
      ST_B0:   out_data = b0_q;
      ST_B1:   out_data = b1_q;
      ST_ECC:  out_data = ecc_q;
      ST_PAY: begin
        out_valid = null_q || pay_valid;
        out_data  = pay_byte;
      end
      ST_CRCL: out_data = crc_val[7:0];
      ST_CRCH: out_data = crc_val[15:8];
      default: out_valid = 1'b0;
    endcase
  end

  assign out_first = (st_q == ST_DI);
  assign out_last  = ((st_q == ST_ECC) && !long_q) || (st_q == ST_CRCH);
  assign req_ready = (st_q == ST_IDLE);
  assign pay_ready = (st_q == ST_PAY) && !null_q;

  // R2
  di_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> out_valid && out_first && (out_data == $past(di_in)));

  // R4
  ecc_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_first, 3) && $past(out_valid, 3) |-> out_data[7:6] == 2'b00);

  // R8
  crc_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_pay |=> out_valid && (st_q == ST_CRCL));

  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready && !pay_valid |=> $stable(left_q) && (st_q == ST_PAY));

  // R9
  null_no_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_fire && null_q |-> !pay_ready && (out_data == 8'h00));

  // R12
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);

endmodule

// File: tb/tb_dsi_pkt_builder.sv
`timescale 1ns/1ps
module tb_dsi_pkt_builder;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [1:0]  req_vc;
  logic [5:0]  req_dtype;
  logic [15:0] req_word;
  logic        pay_valid, pay_ready;
  logic [7:0]  pay_data;
  logic        out_valid, out_first, out_last;
  logic [7:0]  out_data;

  always #5 clk = ~clk;

  dsi_pkt_builder dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vc(req_vc), .req_dtype(req_dtype), .req_word(req_word),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .out_valid(out_valid), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );

  int   checks = 0;
  int   fails  = 0;
  int   cyc    = 0;
  logic [7:0] cap [256];
  logic       capf [256];
  logic       capl [256];
  int   ncap = 0;
  int   took_n = 0;
  int   busy_err = 0;
  logic took = 1'b0;
  logic mon_on = 1'b0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid && ncap < 256) begin
        cap[ncap]  = out_data;
        capf[ncap] = out_first;
        capl[ncap] = out_last;
      end
      if (out_valid) ncap++;
      if (out_valid && req_ready) busy_err++;
      took = pay_valid && pay_ready;
      if (took) took_n++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // parity code of each header bit
  function automatic logic [5:0] col_code(input int i);
    case (i)
      0: return 6'h07;  1: return 6'h0B;  2: return 6'h0D;  3: return 6'h0E;
      4: return 6'h13;  5: return 6'h15;  6: return 6'h16;  7: return 6'h19;
      8: return 6'h1A;  9: return 6'h1C; 10: return 6'h23; 11: return 6'h25;
     12: return 6'h26; 13: return 6'h29; 14: return 6'h2A; 15: return 6'h2C;
     16: return 6'h31; 17: return 6'h32; 18: return 6'h34; 19: return 6'h38;
     20: return 6'h1F; 21: return 6'h2F; 22: return 6'h37; default: return 6'h3B;
    endcase
  endfunction

  function automatic logic [7:0] ref_ecc(input logic [23:0] d);
    logic [5:0] e = 6'h00;
    for (int i = 0; i < 24; i++) if (d[i]) e = e ^ col_code(i);
    return {2'b00, e};
  endfunction

  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r = c;
    for (int i = 0; i < 8; i++) begin
      logic fb;
      fb = r[0] ^ b[i];
      r  = {1'b0, r[15:1]};
      r[15] = r[15] ^ fb;
      r[10] = r[10] ^ fb;
      r[3]  = r[3]  ^ fb;
    end
    return r;
  endfunction

  function automatic logic [7:0] pbyte(input int i, input logic [15:0] w);
    return 8'((i * 37) + int'(w[7:0]) + 5);
  endfunction

  task automatic run_pkt(input logic [1:0] vc, input logic [5:0] dt,
                         input logic [15:0] word, input bit stall, input string tag);
    logic [7:0]  exp [256];
    logic        lng, nul, syn;
    logic [15:0] wc, crc;
    logic [7:0]  b0, b1;
    int          explen, idx, k, nf, nl;
    lng = (dt == 6'h39) || (dt == 6'h09) || (dt == 6'h3E) || (dt == 6'h0E);
    nul = (dt == 6'h09);
    syn = (dt == 6'h01) || (dt == 6'h11) || (dt == 6'h21) || (dt == 6'h31);
    if (dt == 6'h3E)      wc = 16'(word * 3);
    else if (dt == 6'h0E) wc = 16'(word * 2);
    else                  wc = word;
    if (lng)      begin b0 = wc[7:0];   b1 = wc[15:8];   end
    else if (syn) begin b0 = 8'h00;     b1 = 8'h00;      end
    else          begin b0 = word[7:0]; b1 = word[15:8]; end
    exp[0] = {vc, dt};
    exp[1] = b0;
    exp[2] = b1;
    exp[3] = ref_ecc({b1, b0, vc, dt});
    explen = 4;
    if (lng) begin
      crc = 16'hFFFF;
      for (int i = 0; i < int'(wc); i++) begin
        exp[4+i] = nul ? 8'h00 : pbyte(i, word);
        crc = ref_crc(crc, exp[4+i]);
      end
      exp[4+int'(wc)] = crc[7:0];
      exp[5+int'(wc)] = crc[15:8];
      explen = 6 + int'(wc);
    end

    @(posedge clk); #1;
    ncap = 0; took_n = 0; busy_err = 0;
    req_vc = vc; req_dtype = dt; req_word = word; req_valid = 1'b1;
    pay_valid = 1'b0;
    @(posedge clk); #1;
    req_valid = 1'b0;
    idx = 0; k = 0;
    while (ncap < explen && k < 2000) begin
      if (nul) begin
        pay_valid = 1'b1;
        pay_data  = 8'hAA;
      end else begin
        pay_valid = (idx < int'(wc)) && !(stall && (k % 3 == 1));
        pay_data  = pbyte(idx, word);
      end
      @(posedge clk); #1;
      if (took) idx++;
      k++;
    end
    pay_valid = 1'b0;
    repeat (3) @(posedge clk);
    #1;

    chk(ncap == explen, {tag, " byte count"}, ncap, explen);
    nf = 0; nl = 0;
    for (int i = 0; i < explen && i < ncap; i++) begin
      chk(cap[i] == exp[i], $sformatf("%s byte %0d", tag, i), int'(cap[i]), int'(exp[i]));
      if (capf[i]) nf++;
      if (capl[i]) nl++;
    end
    // R2 and R5: markers on first and final byte only
    chk(capf[0] == 1'b1 && nf == 1, {tag, " R2 first marker"}, nf, 1);
    chk(capl[explen-1] == 1'b1 && nl == 1, {tag, " R5 last marker"}, nl, 1);
    // R8 and R9: bytes pulled from payload stream
    chk(took_n == ((lng && !nul) ? int'(wc) : 0), {tag, " R8 payload pulls"},
        took_n, (lng && !nul) ? int'(wc) : 0);
    // R12
    chk(busy_err == 0 && req_ready == 1'b1, {tag, " R12 ready while busy"}, busy_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vc = '0; req_dtype = '0; req_word = '0;
    pay_valid = 1'b0; pay_data = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    @(negedge clk);
    // R1
    chk(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    chk(req_ready == 1'b1, "R1 req_ready after reset", int'(req_ready), 1);
    chk(pay_ready == 1'b0, "R1 pay_ready after reset", int'(pay_ready), 0);

    // R4 known header: 05 11 00 -> 36
    chk(ref_ecc(24'h001105) == 8'h36, "R4 bench ecc model", int'(ref_ecc(24'h001105)), 8'h36);
    run_pkt(2'd0, 6'h05, 16'h0011, 1'b0, "R3 R4 short write no param");
    run_pkt(2'd2, 6'h15, 16'hA53C, 1'b0, "R2 R3 short write one param");
    run_pkt(2'd1, 6'h37, 16'h0100, 1'b0, "R3 max return size");
    run_pkt(2'd3, 6'h2F, 16'hFFFF, 1'b0, "R4 all-ones header");
    // R10 sync events ignore word
    run_pkt(2'd3, 6'h01, 16'hBEEF, 1'b0, "R10 vsync start");
    run_pkt(2'd0, 6'h11, 16'h1234, 1'b0, "R10 vsync end");
    run_pkt(2'd1, 6'h21, 16'h00FF, 1'b0, "R10 hsync start");
    run_pkt(2'd2, 6'h31, 16'hFF00, 1'b0, "R10 hsync end");
    // R5 R7 long write
    run_pkt(2'd1, 6'h39, 16'd7, 1'b0, "R5 R7 long write");
    run_pkt(2'd2, 6'h39, 16'd0, 1'b0, "R7 zero payload");
    run_pkt(2'd0, 6'h39, 16'd1, 1'b0, "R8 single byte");
    // R9 null packet
    run_pkt(2'd3, 6'h09, 16'd5, 1'b0, "R9 null packet");
    // R6 pixel streams
    run_pkt(2'd0, 6'h3E, 16'd4, 1'b0, "R6 24-bit pixels");
    run_pkt(2'd1, 6'h0E, 16'd5, 1'b0, "R6 16-bit pixels");
    // R11 stalled payload
    run_pkt(2'd2, 6'h39, 16'd9, 1'b1, "R11 stalled payload");
    run_pkt(2'd3, 6'h3E, 16'd3, 1'b1, "R11 stalled pixels");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule